// File: doc/BRIEF.md
# SD Host Partial Reset Controller

This block sequences the software-requested resets of an SD/eMMC host controller. Software writes a request byte at a fixed register offset. Each of the three low bits asks for a reset of a different scope: the whole controller, the command path only, or the data path only. For every scope that is pending, the block drives a reset strobe for that domain. It also holds a compact model of the status and control flags that each scope clears, so that the clearing can be observed at its ports.

A command-path or data-path request lasts exactly one cycle. The pending bit reads back as 1 for that cycle and then returns to 0, so software can poll for completion. A whole-controller request stays pending, and keeps its strobe asserted, until the capabilities-valid input is sampled high. The live line-level and card-presence bits are sampled every clock. No software reset ever touches them.

Top module: `sdh_swreset_ctrl`

## Requirements
- R1: After the hardware reset (rst_n low), the read value at the request offset is 0, all three strobes are low and every modelled status bit is 0.
- R2: A read at offset 0x2F returns {5'b0, data-pending, command-pending, full-pending}, with full at bit 0, command at bit 1 and data at bit 2. Any other read offset returns 0, and writes to any other offset are ignored.
- R3: A write with bit 1 set at offset 0x2F sets command-pending on the next edge. rst_cmd_o is high for exactly that one cycle, and command-pending clears on the edge after.
- R4: The command strobe clears status bits 13 (command inhibit) and 14 (command-complete flag) and leaves every other status bit unchanged.
- R5: The data strobe clears status bits 0 to 12 (buffer read/write enables, read/write active, data-line active, data inhibit, continue request, stop-at-gap request, and the buffer-read-ready, buffer-write-ready, DMA, gap-event and transfer-complete flags). It leaves bits 13 and up unchanged.
- R6: While rst_all_o is high, every status bit is cleared on each edge.
- R7: Full-pending, requested by bit 0, stays set while caps_valid is sampled low. It clears on the first edge at which caps_valid is sampled high.
- R8: While full-pending is set, rst_cmd_o and rst_dat_o stay low even if their own requests are pending.
- R9: live_q follows live_in one cycle later and is never cleared by any software reset.
- R10: Writing 0 to a pending bit does not cancel it, and bits 7:3 of the request byte have no effect.
- R11: In a cycle where a strobe clears a status bit, a simultaneous stat_set pulse on that bit is lost. Otherwise stat_set sets the bit and it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| wr_valid | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write offset |
| wr_data | input | 8 | Write data |
| rd_addr | input | 8 | Read offset |
| rd_data | output | 8 | Read data (combinational) |
| caps_valid | input | 1 | Capability registers valid; ends a full reset |
| stat_set | input | 19 | Per-bit set pulses for the modelled status flags |
| stat_q | output | 19 | Modelled status and control flags |
| live_in | input | 6 | Live line-level and card-state inputs |
| live_q | output | 6 | Registered live bits, immune to software reset |
| rst_all_o | output | 1 | Whole-controller reset strobe |
| rst_cmd_o | output | 1 | Command-path reset strobe |
| rst_dat_o | output | 1 | Data-path reset strobe |

## Verification
The assertions assume that caps_valid is a level which software-side logic raises only once the capability values are settled. They also assume that stat_set may pulse in any cycle, including cycles in which a strobe is active. The stimulus holds caps_valid low for several cycles of a pending full reset before raising it. It deliberately drives stat_set in strobe cycles, so that clear-over-set ordering is exercised rather than avoided. Writes are made one per cycle, with combined and reserved bit patterns, at both the request offset and a neighbouring one.

// File: rtl/sdh_rst_pkg.sv
package sdh_rst_pkg;
   // Status bit layout: data-path group, then command-path group, then full-only bits
   localparam int unsigned SDH_DAT_LO  = 0;
   localparam int unsigned SDH_DAT_N   = 13;
   localparam int unsigned SDH_CMD_LO  = 13;
   localparam int unsigned SDH_CMD_N   = 2;
   localparam int unsigned SDH_FIXED_W = 15;

   typedef struct packed {
      logic dat;
      logic cmd;
      logic all;
   } sdh_scope_t;
endpackage

// File: rtl/sdh_rst_req.sv
module sdh_rst_req
   import sdh_rst_pkg::*;
#(
   parameter int unsigned        ADDR_W         = 8,
   parameter logic [ADDR_W-1:0]  REG_OFS        = 'h2F,
   parameter bit                 SUPPRESS_LOWER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic              caps_valid,
   output sdh_scope_t        pend_q,
   output sdh_scope_t        strobe
);
   logic       hit;
   sdh_scope_t req;
   logic       unused_hi;

   assign hit       = wr_valid && (wr_addr == REG_OFS);
   assign req       = hit ? sdh_scope_t'(wr_data[2:0]) : '0;
   assign unused_hi = ^wr_data[7:3];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
      end else begin
         pend_q.cmd <= req.cmd;
         pend_q.dat <= req.dat;
         if (req.all)
            pend_q.all <= 1'b1;
         else if (pend_q.all && caps_valid)
            pend_q.all <= 1'b0;
      end
   end

   generate
      if (SUPPRESS_LOWER) begin : g_suppress
         assign strobe.all = pend_q.all;
         assign strobe.cmd = pend_q.cmd && !pend_q.all;
         assign strobe.dat = pend_q.dat && !pend_q.all;
      end else begin : g_overlap
         assign strobe = pend_q;
      end
   endgenerate

   // R3
   cmd_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q.cmd && !req.cmd) |=> !pend_q.cmd);
   // R7
   all_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q.all && !caps_valid) |=> pend_q.all);
   // R7
   all_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q.all && caps_valid && !req.all) |=> !pend_q.all);
endmodule

// File: rtl/sdh_rst_stat.sv
module sdh_rst_stat
   import sdh_rst_pkg::*;
#(
   parameter int unsigned STAT_W = 19
) (
   input  logic              clk,
   input  logic              rst_n,
   input  sdh_scope_t        strobe,
   input  logic [STAT_W-1:0] stat_set,
   output logic [STAT_W-1:0] stat_q
);
   function automatic logic [STAT_W-1:0] span(input int unsigned lo, input int unsigned n);
      logic [STAT_W-1:0] m;
      m = '0;
      for (int unsigned k = 0; k < STAT_W; k++)
         if (k >= lo && k < lo + n) m[k] = 1'b1;
      return m;
   endfunction

   localparam logic [STAT_W-1:0] DAT_MASK = span(SDH_DAT_LO, SDH_DAT_N);
   localparam logic [STAT_W-1:0] CMD_MASK = span(SDH_CMD_LO, SDH_CMD_N);

   logic [STAT_W-1:0] clr;

   assign clr = ({STAT_W{strobe.all}})
              | ({STAT_W{strobe.cmd}} & CMD_MASK)
              | ({STAT_W{strobe.dat}} & DAT_MASK);

   for (genvar i = 0; i < STAT_W; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            stat_q[i] <= 1'b0;
         else if (clr[i])
            stat_q[i] <= 1'b0;
         else if (stat_set[i])
            stat_q[i] <= 1'b1;
      end
   end

   // R6
   full_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe.all |=> (stat_q == '0));
   // R4
   cmd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe.cmd |=> ((stat_q & CMD_MASK) == '0));
   // R5
   dat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe.dat |=> ((stat_q & DAT_MASK) == '0));
endmodule

// File: rtl/sdh_rst_live.sv
module sdh_rst_live #(
   parameter int unsigned LIVE_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LIVE_W-1:0] live_in,
   output logic [LIVE_W-1:0] live_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live_q <= '0;
      else        live_q <= live_in;
   end
endmodule

// File: rtl/sdh_swreset_ctrl.sv
module sdh_swreset_ctrl
   import sdh_rst_pkg::*;
#(
   parameter int unsigned       ADDR_W         = 8,
   parameter logic [ADDR_W-1:0] REG_OFS        = 'h2F,
   parameter int unsigned       N_OTHER        = 4,
   parameter int unsigned       LIVE_W         = 6,
   parameter bit                SUPPRESS_LOWER = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_valid,
   input  logic [ADDR_W-1:0]              wr_addr,
   input  logic [7:0]                     wr_data,
   input  logic [ADDR_W-1:0]              rd_addr,
   output logic [7:0]                     rd_data,
   input  logic                           caps_valid,
   input  logic [SDH_FIXED_W+N_OTHER-1:0] stat_set,
   output logic [SDH_FIXED_W+N_OTHER-1:0] stat_q,
   input  logic [LIVE_W-1:0]              live_in,
   output logic [LIVE_W-1:0]              live_q,
   output logic                           rst_all_o,
   output logic                           rst_cmd_o,
   output logic                           rst_dat_o
);
   localparam int unsigned STAT_W = SDH_FIXED_W + N_OTHER;

   if (N_OTHER < 1) begin : g_bad_other
      $error("N_OTHER must be at least 1");
   end
   if (LIVE_W < 1) begin : g_bad_live
      $error("LIVE_W must be at least 1");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("ADDR_W too narrow for the request offset");
   end

   sdh_scope_t pend;
   sdh_scope_t strobe;

   sdh_rst_req #(
      .ADDR_W(ADDR_W), .REG_OFS(REG_OFS), .SUPPRESS_LOWER(SUPPRESS_LOWER)
   ) i_req (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
      .wr_data(wr_data), .caps_valid(caps_valid), .pend_q(pend), .strobe(strobe)
   );

   sdh_rst_stat #(.STAT_W(STAT_W)) i_stat (
      .clk(clk), .rst_n(rst_n), .strobe(strobe), .stat_set(stat_set), .stat_q(stat_q)
   );

   sdh_rst_live #(.LIVE_W(LIVE_W)) i_live (
      .clk(clk), .rst_n(rst_n), .live_in(live_in), .live_q(live_q)
   );

   assign rd_data   = (rd_addr == REG_OFS) ? {5'b0, pend} : 8'h00;
   assign rst_all_o = strobe.all;
   assign rst_cmd_o = strobe.cmd;
   assign rst_dat_o = strobe.dat;

   if (SUPPRESS_LOWER) begin : g_quiet_chk
      // R8
      lower_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rst_all_o |-> (!rst_cmd_o && !rst_dat_o));
   end

   // R9
   live_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_all_o |=> (live_q == $past(live_in)));
endmodule

// File: tb/test_sdh_swreset_ctrl.sv
module test_sdh_swreset_ctrl;
   localparam int STW = 19;
   localparam logic [STW-1:0] ONES = 19'h7FFFF;

   typedef struct {
      int          kind;   // 0 rd_data, 1 stat_q, 2 strobes {dat,cmd,all}, 3 live_q
      logic [31:0] exp;
      string       req;
   } item_t;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           wr_valid = 1'b0;
   logic [7:0]     wr_addr = '0, wr_data = '0, rd_addr = 8'h2F;
   logic           caps_valid = 1'b0;
   logic [STW-1:0] stat_set = '0;
   logic [5:0]     live_in = 6'h2A;
   logic [7:0]     rd_data;
   logic [STW-1:0] stat_q;
   logic [5:0]     live_q;
   logic           rst_all_o, rst_cmd_o, rst_dat_o;

   item_t q[$];
   int n_cmp = 0, n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   sdh_swreset_ctrl i_sdh_swreset_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .caps_valid(caps_valid), .stat_set(stat_set), .stat_q(stat_q),
      .live_in(live_in), .live_q(live_q), .rst_all_o(rst_all_o),
      .rst_cmd_o(rst_cmd_o), .rst_dat_o(rst_dat_o)
   );

   task automatic cyc(input logic wv, input logic [7:0] wa, input logic [7:0] wd,
                      input logic [STW-1:0] set, input logic cv, input logic [7:0] ra);
      @(negedge clk);
      wr_valid = wv; wr_addr = wa; wr_data = wd;
      stat_set = set; caps_valid = cv; rd_addr = ra;
   endtask

   task automatic expect_item(input int kind, input logic [31:0] val, input string req);
      item_t it;
      it.kind = kind; it.exp = val; it.req = req;
      q.push_back(it);
   endtask

   task automatic expect_all(input logic [7:0] rd, input logic [STW-1:0] st,
                             input logic [2:0] sb, input string req);
      expect_item(0, 32'(rd), req);
      expect_item(1, 32'(st), req);
      expect_item(2, 32'(sb), req);
   endtask

   // monitor: compares after each edge
   initial begin
      forever begin
         @(posedge clk);
         #5;
         while (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            case (it.kind)
               0:       act = 32'(rd_data);
               1:       act = 32'(stat_q);
               2:       act = 32'({rst_dat_o, rst_cmd_o, rst_all_o});
               default: act = 32'(live_q);
            endcase
            n_cmp++;
            if (act !== it.exp) begin
               n_bad++;
               $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      cyc(0, 8'h00, 8'h00, '0, 0, 8'h2F);           expect_all(8'h00, '0, 3'b000, "R1");
      cyc(0, 8'h00, 8'h00, ONES, 0, 8'h2F);         expect_all(8'h00, ONES, 3'b000, "R11");
      // command-path reset
      cyc(1, 8'h2F, 8'h02, '0, 0, 8'h2F);           expect_all(8'h02, ONES, 3'b010, "R3");
      cyc(0, 8'h00, 8'h00, '0, 0, 8'h2F);           expect_all(8'h00, 19'h79FFF, 3'b000, "R4");
      expect_item(3, 32'h2A, "R9");
      // data-path reset, with a set on bit 13 during the strobe
      cyc(1, 8'h2F, 8'h04, '0, 0, 8'h2F);           expect_all(8'h04, 19'h79FFF, 3'b100, "R2");
      cyc(0, 8'h00, 8'h00, 19'h02000, 0, 8'h2F);    expect_all(8'h00, 19'h7A000, 3'b000, "R5");
      // clear beats set
      cyc(1, 8'h2F, 8'h04, 19'h00001, 0, 8'h2F);    expect_all(8'h04, 19'h7A001, 3'b100, "R11");
      cyc(0, 8'h00, 8'h00, 19'h00003, 0, 8'h2F);    expect_all(8'h00, 19'h7A000, 3'b000, "R11");
      // reserved bits and other offset
      cyc(1, 8'h2F, 8'hF8, '0, 0, 8'h2F);           expect_all(8'h00, 19'h7A000, 3'b000, "R10");
      cyc(1, 8'h2E, 8'h07, '0, 0, 8'h2F);           expect_all(8'h00, 19'h7A000, 3'b000, "R2");
      // full reset held by caps_valid low
      cyc(0, 8'h00, 8'h00, ONES, 0, 8'h2F);         expect_all(8'h00, ONES, 3'b000, "R11");
      cyc(1, 8'h2F, 8'h07, '0, 0, 8'h2F);           expect_all(8'h07, ONES, 3'b001, "R8");
      cyc(0, 8'h00, 8'h00, ONES, 0, 8'h2F);         expect_all(8'h01, '0, 3'b001, "R6");
      cyc(0, 8'h00, 8'h00, '0, 0, 8'h2E);           expect_all(8'h00, '0, 3'b001, "R2");
      cyc(1, 8'h2F, 8'h00, '0, 0, 8'h2F);           expect_all(8'h01, '0, 3'b001, "R10");
      cyc(0, 8'h00, 8'h00, '0, 0, 8'h2F);           expect_all(8'h01, '0, 3'b001, "R7");
      cyc(0, 8'h00, 8'h00, '0, 1, 8'h2F);           expect_all(8'h00, '0, 3'b000, "R7");
      expect_item(3, 32'h2A, "R9");
      // full reset with caps already valid
      cyc(1, 8'h2F, 8'h01, '0, 1, 8'h2F);           expect_all(8'h01, '0, 3'b001, "R7");
      cyc(0, 8'h00, 8'h00, '0, 1, 8'h2F);           expect_all(8'h00, '0, 3'b000, "R7");
      cyc(1, 8'h2F, 8'h03, 19'h06000, 1, 8'h2F);    expect_all(8'h03, 19'h06000, 3'b001, "R8");
      cyc(0, 8'h00, 8'h00, '0, 1, 8'h2F);           expect_all(8'h00, '0, 3'b000, "R6");
      live_in = 6'h15;
      cyc(0, 8'h00, 8'h00, '0, 1, 8'h2F);           expect_item(3, 32'h15, "R9");
      cyc(0, 8'h00, 8'h00, '0, 1, 8'h2F);
      @(posedge clk);
      #6;
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule